// File: doc/BRIEF.md
# Accumulator ALU with Flag Update

This block is the arithmetic and logic core of an 8-bit accumulator processor. It is purely combinational. Each cycle the sequencer presents an operation code, a register operand (the accumulator, or an index register for compares), a memory operand and the current carry. Within the same cycle the block returns a result byte, a modified memory byte, new negative, overflow, zero and carry values, and a mask saying which of those four flags the sequencer should commit.

Some operations act on a single operand: shifts, rotates, increment, decrement and a plain transfer. To apply one of them to a register, the sequencer feeds that register in as the memory operand. The combined read-modify-write operations do two things in one evaluation. They first modify the memory operand, then combine the modified byte with the register operand. The modified byte appears on its own output so that it can be written back separately from the accumulator result. Decimal arithmetic is not supported, so no decimal flag enters the block.

Top module: `accum_alu`

## Requirements
- R1: Code 0 (add) gives result = reg + mem + carryIn, modulo 256. C is set when the true sum exceeds 0xFF. V is set when reg and mem have the same sign and the result sign differs from reg. The mask is 0xF, where mask bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C.
- R2: Code 1 (subtract) gives result = reg + ~mem + carryIn. C set means no borrow. V follows the R1 sign rule with ~mem as the second operand. The mask is 0xF.
- R3: Codes 2, 3 and 4 (AND, OR, XOR) combine reg with mem. N and Z come from the result. The mask is 0xA.
- R4: Code 5 (compare) returns reg unchanged as the result. N and Z come from the 8-bit value reg − mem. C is set when mem ≤ reg as unsigned numbers, whatever carryIn is. The mask is 0xB, so V is never written.
- R5: Code 6 (bit test) returns reg unchanged. N = mem bit 7, V = mem bit 6, and Z is set when reg AND mem is zero. The mask is 0xE.
- R6: Code 7 (shift left) moves mem bit 7 into C and a 0 into bit 0. Code 8 (shift right) moves mem bit 0 into C and a 0 into bit 7, so N is always 0. Result and memOut both carry the shifted byte. The mask is 0xB.
- R7: Code 9 (rotate left) moves carryIn into bit 0 and bit 7 into C. Code 10 (rotate right) moves carryIn into bit 7 and bit 0 into C. The mask is 0xB.
- R8: Codes 11 (increment), 12 (decrement) and 13 (transfer of mem) set N and Z from the new byte and have mask 0xA. Increment and decrement present the new byte on memOut.
- R9: Code 14 decrements mem, presents the decremented byte on memOut, then compares reg against it under the R4 rules. The result is reg and the mask is 0xB.
- R10: Code 15 increments mem, presents it on memOut, then subtracts it from reg with borrow under the R2 rules. The mask is 0xF.
- R11: Codes 16 (shift left then OR), 17 (rotate left then AND) and 18 (shift right then XOR) put the shifted byte on memOut and combine it with reg into the result. C comes from the shift, N and Z come from the result rather than from the shifted byte, and the mask is 0xB.
- R12: Code 19 rotates mem right through carry onto memOut. It then adds the rotated byte to reg, using the carry produced by the rotate as the carry-in, under the R1 rules. The mask is 0xF.
- R13: Codes 0 to 6 and 13 present memOut equal to mem unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 5 | Operation code (values in R1–R12) |
| regIn | input | 8 | Accumulator or index register operand |
| memIn | input | 8 | Memory operand |
| carryIn | input | 1 | Current carry flag |
| result | output | 8 | Register-side result byte |
| memOut | output | 8 | Modified memory byte for write-back |
| flagN | output | 1 | New negative flag |
| flagV | output | 1 | New overflow flag |
| flagZ | output | 1 | New zero flag |
| flagC | output | 1 | New carry flag |
| wrMask | output | 4 | Flag write enables {N, V, Z, C} |

## Verification
The block holds no state, so a wrong internal value, such as a mis-decoded strobe or the wrong carry fed into the adder, shows up on the outputs in the same evaluation as the input that exposes it. The checks that catch such faults most sharply are the combined operations. A stage-one carry that does not reach stage two, or N and Z taken from the memory byte instead of the accumulator, leaves plain operations correct but makes the chained cases differ at once. Mask errors show directly on wrMask. A flag that should be left untouched, such as V on a compare, is verified through that mask rather than through the flag value.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int OP_BITS = 5;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_AND    = 5'd2,
    OP_OR     = 5'd3,
    OP_XOR    = 5'd4,
    OP_CMP    = 5'd5,
    OP_BIT    = 5'd6,
    OP_SHL    = 5'd7,
    OP_SHR    = 5'd8,
    OP_ROL    = 5'd9,
    OP_ROR    = 5'd10,
    OP_INC    = 5'd11,
    OP_DEC    = 5'd12,
    OP_PASS   = 5'd13,
    OP_DECCMP = 5'd14,
    OP_INCSUB = 5'd15,
    OP_SHLOR  = 5'd16,
    OP_ROLAND = 5'd17,
    OP_SHRXOR = 5'd18,
    OP_RORADD = 5'd19
  } aluOp_e;

  // stage one: what happens to the memory operand
  typedef enum logic [2:0] {
    U_NONE, U_SHL, U_SHR, U_ROL, U_ROR, U_INC, U_DEC
  } unaryKind_e;

  // stage two: how the (modified) memory byte meets the register operand
  typedef enum logic [2:0] {
    B_PASS, B_ADD, B_SUB, B_AND, B_OR, B_XOR, B_CMP, B_BIT
  } binKind_e;

  // mask bit positions
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 2;
  localparam int FLAG_N = 3;

  localparam logic [3:0] MASK_NZ   = 4'b1010;
  localparam logic [3:0] MASK_NZC  = 4'b1011;
  localparam logic [3:0] MASK_NVZ  = 4'b1110;
  localparam logic [3:0] MASK_NVZC = 4'b1111;

  typedef struct packed {
    unaryKind_e unaryKind;
    binKind_e   binKind;
    logic [3:0] flagWe;
    logic       holdReg;
  } ctrlStrobes_t;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic [OP_BITS-1:0] opSel,
  output ctrlStrobes_t       strobes
);

  always_comb begin
    strobes = '{unaryKind: U_NONE, binKind: B_PASS, flagWe: 4'b0000, holdReg: 1'b1};
    case (opSel)
      OP_ADD:    strobes = '{U_NONE, B_ADD, MASK_NVZC, 1'b0};
      OP_SUB:    strobes = '{U_NONE, B_SUB, MASK_NVZC, 1'b0};
      OP_AND:    strobes = '{U_NONE, B_AND, MASK_NZ,   1'b0};
      OP_OR:     strobes = '{U_NONE, B_OR,  MASK_NZ,   1'b0};
      OP_XOR:    strobes = '{U_NONE, B_XOR, MASK_NZ,   1'b0};
      OP_CMP:    strobes = '{U_NONE, B_CMP, MASK_NZC,  1'b0};
      OP_BIT:    strobes = '{U_NONE, B_BIT, MASK_NVZ,  1'b0};
      OP_SHL:    strobes = '{U_SHL,  B_PASS, MASK_NZC, 1'b0};
      OP_SHR:    strobes = '{U_SHR,  B_PASS, MASK_NZC, 1'b0};
      OP_ROL:    strobes = '{U_ROL,  B_PASS, MASK_NZC, 1'b0};
      OP_ROR:    strobes = '{U_ROR,  B_PASS, MASK_NZC, 1'b0};
      OP_INC:    strobes = '{U_INC,  B_PASS, MASK_NZ,  1'b0};
      OP_DEC:    strobes = '{U_DEC,  B_PASS, MASK_NZ,  1'b0};
      OP_PASS:   strobes = '{U_NONE, B_PASS, MASK_NZ,  1'b0};
      OP_DECCMP: strobes = '{U_DEC,  B_CMP, MASK_NZC,  1'b0};
      OP_INCSUB: strobes = '{U_INC,  B_SUB, MASK_NVZC, 1'b0};
      OP_SHLOR:  strobes = '{U_SHL,  B_OR,  MASK_NZC,  1'b0};
      OP_ROLAND: strobes = '{U_ROL,  B_AND, MASK_NZC,  1'b0};
      OP_SHRXOR: strobes = '{U_SHR,  B_XOR, MASK_NZC,  1'b0};
      OP_RORADD: strobes = '{U_ROR,  B_ADD, MASK_NVZC, 1'b0};
      default:   ;
    endcase
  end

endmodule

// File: rtl/accum_alu_datapath.sv
module accum_alu_datapath
  import accum_alu_pkg::*;
#(
  parameter int WIDTH = 8
)(
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] regIn,
  input  logic [WIDTH-1:0] memIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] memOut,
  output logic             flagN,
  output logic             flagV,
  output logic             flagZ,
  output logic             flagC
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] modVal;
  logic             shiftCarry;
  logic [WIDTH-1:0] addB;
  logic             addCin;
  logic [WIDTH:0]   sumFull;
  logic [WIDTH-1:0] sumVal;
  logic             addOvf;
  logic [WIDTH-1:0] nzSrc;

  // stage one: modify the memory operand
  always_comb begin
    modVal     = memIn;
    shiftCarry = carryIn;
    case (strobes.unaryKind)
      U_SHL: begin modVal = {memIn[MSB-1:0], 1'b0};    shiftCarry = memIn[MSB]; end
      U_SHR: begin modVal = {1'b0, memIn[MSB:1]};      shiftCarry = memIn[0];   end
      U_ROL: begin modVal = {memIn[MSB-1:0], carryIn}; shiftCarry = memIn[MSB]; end
      U_ROR: begin modVal = {carryIn, memIn[MSB:1]};   shiftCarry = memIn[0];   end
      U_INC: modVal = memIn + WIDTH'(1);
      U_DEC: modVal = memIn - WIDTH'(1);
      default: ;
    endcase
  end

  // shared adder: add, subtract-as-add-of-complement, compare
  always_comb begin
    addB    = (strobes.binKind == B_ADD) ? modVal : ~modVal;
    addCin  = (strobes.binKind == B_CMP) ? 1'b1 : shiftCarry;
    sumFull = {1'b0, regIn} + {1'b0, addB} + {{WIDTH{1'b0}}, addCin};
    sumVal  = sumFull[MSB:0];
    addOvf  = ~(regIn[MSB] ^ addB[MSB]) & (regIn[MSB] ^ sumVal[MSB]);
  end

  // stage two: combine and form flags
  always_comb begin
    result = regIn;
    nzSrc  = modVal;
    flagC  = shiftCarry;
    flagV  = 1'b0;
    case (strobes.binKind)
      B_PASS: begin result = modVal; nzSrc = modVal; end
      B_ADD, B_SUB: begin
        result = sumVal; nzSrc = sumVal; flagC = sumFull[WIDTH]; flagV = addOvf;
      end
      B_AND: begin result = regIn & modVal; nzSrc = regIn & modVal; end
      B_OR:  begin result = regIn | modVal; nzSrc = regIn | modVal; end
      B_XOR: begin result = regIn ^ modVal; nzSrc = regIn ^ modVal; end
      B_CMP: begin result = regIn; nzSrc = sumVal; flagC = sumFull[WIDTH]; end
      B_BIT: begin result = regIn; nzSrc = regIn & modVal; end
      default: ;
    endcase
    if (strobes.holdReg) result = regIn;
    flagZ = (nzSrc == '0);
    flagN = nzSrc[MSB];
    if (strobes.binKind == B_BIT) begin
      flagN = modVal[MSB];
      flagV = modVal[MSB-1];
    end
  end

  assign memOut = modVal;

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int WIDTH = 8
)(
  input  logic [OP_BITS-1:0] opSel,
  input  logic [WIDTH-1:0]   regIn,
  input  logic [WIDTH-1:0]   memIn,
  input  logic               carryIn,
  output logic [WIDTH-1:0]   result,
  output logic [WIDTH-1:0]   memOut,
  output logic               flagN,
  output logic               flagV,
  output logic               flagZ,
  output logic               flagC,
  output logic [3:0]         wrMask
);

  ctrlStrobes_t strobes;

  accum_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  accum_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobes (strobes),
    .regIn   (regIn),
    .memIn   (memIn),
    .carryIn (carryIn),
    .result  (result),
    .memOut  (memOut),
    .flagN   (flagN),
    .flagV   (flagV),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );

  assign wrMask = strobes.flagWe;

endmodule

// File: rtl/accum_alu_checker.sv
module accum_alu_checker
  import accum_alu_pkg::*;
#(
  parameter int WIDTH = 8
)(
  input logic [OP_BITS-1:0] opSel,
  input logic [WIDTH-1:0]   regIn,
  input logic [WIDTH-1:0]   memIn,
  input logic               carryIn,
  input logic [WIDTH-1:0]   result,
  input logic [WIDTH-1:0]   memOut,
  input logic               flagN,
  input logic               flagV,
  input logic               flagZ,
  input logic               flagC,
  input logic [3:0]         wrMask
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (opSel == OP_CMP) begin
      a_r4_cmp_unsigned: assert (flagC == (memIn <= regIn) && result == regIn && !wrMask[FLAG_V])
        else $error("compare carry, result or mask wrong");
    end
    if (opSel == OP_BIT) begin
      a_r5_bit_keeps_reg: assert (result == regIn && flagN == memIn[MSB] && flagV == memIn[MSB-1])
        else $error("bit test flags or result wrong");
    end
    if (opSel == OP_SHR) begin
      a_r6_shr_clears_n: assert (!flagN) else $error("shift right produced N");
    end
    if (opSel == OP_INC || opSel == OP_DEC || opSel == OP_PASS) begin
      a_r8_nz_only: assert (wrMask == MASK_NZ) else $error("unary op writes C or V");
    end
    if (opSel == OP_SHLOR || opSel == OP_ROLAND || opSel == OP_SHRXOR) begin
      a_r11_nz_from_acc: assert (flagZ == (result == '0) && flagN == result[MSB])
        else $error("N/Z not taken from accumulator result");
    end
    if (opSel == OP_RORADD) begin
      a_r12_rotate_first: assert (memOut == {carryIn, memIn[MSB:1]})
        else $error("rotate-add stage one wrong");
    end
    if (opSel <= OP_BIT || opSel == OP_PASS) begin
      a_r13_mem_untouched: assert (memOut == memIn) else $error("memOut altered");
    end
  end

endmodule

bind accum_alu accum_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .opSel   (opSel),
  .regIn   (regIn),
  .memIn   (memIn),
  .carryIn (carryIn),
  .result  (result),
  .memOut  (memOut),
  .flagN   (flagN),
  .flagV   (flagV),
  .flagZ   (flagZ),
  .flagC   (flagC),
  .wrMask  (wrMask)
);

// File: tb/accum_alu_bench.sv
module accum_alu_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] regIn = '0;
  logic [7:0] memIn = '0;
  logic       carryIn = 1'b0;
  logic [7:0] result, memOut;
  logic       flagN, flagV, flagZ, flagC;
  logic [3:0] wrMask;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_alu u_accum_alu (
    .opSel(opSel), .regIn(regIn), .memIn(memIn), .carryIn(carryIn),
    .result(result), .memOut(memOut),
    .flagN(flagN), .flagV(flagV), .flagZ(flagZ), .flagC(flagC),
    .wrMask(wrMask)
  );

  // expected flags are given as {N,V,Z,C}; only masked bits are compared
  task automatic runVec(input string tag, input logic [4:0] op, input logic [7:0] r,
                        input logic [7:0] m, input logic c, input logic [7:0] expRes,
                        input logic [7:0] expMem, input logic [3:0] expMask,
                        input logic [3:0] expFlags);
    logic [3:0] gotFlags;
    @(negedge clk);
    opSel = op; regIn = r; memIn = m; carryIn = c;
    #1;
    gotFlags = {flagN, flagV, flagZ, flagC};
    vectors++;
    if (result !== expRes) begin
      miscompares++;
      $display("FAIL %s result got %02h exp %02h", tag, result, expRes);
    end
    if (memOut !== expMem) begin
      miscompares++;
      $display("FAIL %s memOut got %02h exp %02h", tag, memOut, expMem);
    end
    if (wrMask !== expMask) begin
      miscompares++;
      $display("FAIL %s mask got %h exp %h", tag, wrMask, expMask);
    end
    if ((gotFlags & expMask) !== (expFlags & expMask)) begin
      miscompares++;
      $display("FAIL %s flags NVZC got %b exp %b", tag, gotFlags & expMask, expFlags & expMask);
    end
  endtask

  task automatic testIdle();
    runVec("R1 idle zero add", 5'd0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 4'hF, 4'b0010);
  endtask

  task automatic testAdd();
    runVec("R1 add signed ovf", 5'd0, 8'h50, 8'h50, 1'b0, 8'hA0, 8'h50, 4'hF, 4'b1100);
    runVec("R1 add carry out",  5'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h01, 4'hF, 4'b0011);
    runVec("R1 add carry in",   5'd0, 8'h10, 8'h20, 1'b1, 8'h31, 8'h20, 4'hF, 4'b0000);
  endtask

  task automatic testSub();
    runVec("R2 sub borrow",     5'd1, 8'h50, 8'hF0, 1'b1, 8'h60, 8'hF0, 4'hF, 4'b0000);
    runVec("R2 sub overflow",   5'd1, 8'h50, 8'hB0, 1'b1, 8'hA0, 8'hB0, 4'hF, 4'b1100);
    runVec("R2 sub with borrow in", 5'd1, 8'h05, 8'h03, 1'b0, 8'h01, 8'h03, 4'hF, 4'b0001);
  endtask

  task automatic testLogic();
    runVec("R3 and", 5'd2, 8'hF0, 8'h3C, 1'b1, 8'h30, 8'h3C, 4'hA, 4'b0000);
    runVec("R3 or",  5'd3, 8'h80, 8'h01, 1'b0, 8'h81, 8'h01, 4'hA, 4'b1000);
    runVec("R3 xor", 5'd4, 8'h5A, 8'h5A, 1'b0, 8'h00, 8'h5A, 4'hA, 4'b0010);
  endtask

  task automatic testCompare();
    runVec("R4 cmp equal",   5'd5, 8'h40, 8'h40, 1'b0, 8'h40, 8'h40, 4'hB, 4'b0011);
    runVec("R4 cmp less",    5'd5, 8'h10, 8'h20, 1'b1, 8'h10, 8'h20, 4'hB, 4'b1000);
    runVec("R4 cmp greater", 5'd5, 8'h20, 8'h10, 1'b0, 8'h20, 8'h10, 4'hB, 4'b0001);
  endtask

  task automatic testBit();
    runVec("R5 bit zero",    5'd6, 8'h0F, 8'hC0, 1'b0, 8'h0F, 8'hC0, 4'hE, 4'b1110);
    runVec("R5 bit nonzero", 5'd6, 8'h01, 8'h41, 1'b0, 8'h01, 8'h41, 4'hE, 4'b0100);
  endtask

  task automatic testShifts();
    runVec("R6 shl",      5'd7, 8'h00, 8'h81, 1'b0, 8'h02, 8'h02, 4'hB, 4'b0001);
    runVec("R6 shr zero", 5'd8, 8'h00, 8'h01, 1'b0, 8'h00, 8'h00, 4'hB, 4'b0011);
    runVec("R6 shr",      5'd8, 8'h00, 8'hFE, 1'b1, 8'h7F, 8'h7F, 4'hB, 4'b0000);
  endtask

  task automatic testRotates();
    runVec("R7 rol",      5'd9,  8'h00, 8'h80, 1'b1, 8'h01, 8'h01, 4'hB, 4'b0001);
    runVec("R7 ror",      5'd10, 8'h00, 8'h02, 1'b1, 8'h81, 8'h81, 4'hB, 4'b1000);
    runVec("R7 ror zero", 5'd10, 8'h00, 8'h01, 1'b0, 8'h00, 8'h00, 4'hB, 4'b0011);
  endtask

  task automatic testIncDec();
    runVec("R8 inc wrap", 5'd11, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h00, 4'hA, 4'b0010);
    runVec("R8 dec wrap", 5'd12, 8'h00, 8'h00, 1'b0, 8'hFF, 8'hFF, 4'hA, 4'b1000);
    runVec("R8 transfer", 5'd13, 8'h33, 8'h80, 1'b1, 8'h80, 8'h80, 4'hA, 4'b1000);
  endtask

  task automatic testDecCmp();
    runVec("R9 deccmp equal", 5'd14, 8'h10, 8'h11, 1'b0, 8'h10, 8'h10, 4'hB, 4'b0011);
    runVec("R9 deccmp less",  5'd14, 8'h05, 8'h10, 1'b1, 8'h05, 8'h0F, 4'hB, 4'b1000);
  endtask

  task automatic testIncSub();
    runVec("R10 incsub zero", 5'd15, 8'h10, 8'h0F, 1'b1, 8'h00, 8'h10, 4'hF, 4'b0011);
    runVec("R10 incsub ovf",  5'd15, 8'h80, 8'h00, 1'b1, 8'h7F, 8'h01, 4'hF, 4'b0101);
  endtask

  task automatic testShiftLogic();
    runVec("R11 shlor",        5'd16, 8'h01, 8'h81, 1'b0, 8'h03, 8'h02, 4'hB, 4'b0001);
    runVec("R11 shlor acc nz", 5'd16, 8'h01, 8'h80, 1'b0, 8'h01, 8'h00, 4'hB, 4'b0001);
    runVec("R11 roland",       5'd17, 8'hFF, 8'h40, 1'b1, 8'h81, 8'h81, 4'hB, 4'b1000);
    runVec("R11 shrxor",       5'd18, 8'h80, 8'h02, 1'b1, 8'h81, 8'h01, 4'hB, 4'b1000);
  endtask

  task automatic testRorAdd();
    runVec("R12 roradd carry chain", 5'd19, 8'h10, 8'h03, 1'b0, 8'h12, 8'h01, 4'hF, 4'b0000);
    runVec("R12 roradd carry in",    5'd19, 8'h7F, 8'h00, 1'b1, 8'hFF, 8'h80, 4'hF, 4'b1000);
    runVec("R12 roradd overflow",    5'd19, 8'h40, 8'h80, 1'b0, 8'h80, 8'h40, 4'hF, 4'b1100);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testIdle();
    testAdd();
    testSub();
    testLogic();       // R13 memOut passthrough also checked here
    testCompare();
    testBit();
    testShifts();
    testRotates();
    testIncDec();
    testDecCmp();
    testIncSub();
    testShiftLogic();
    testRorAdd();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule